// File: doc/BRIEF.md
# Interleaved Slot Read Multiplexer

This block returns read data from a row of equal-sized resource slots to a static bus master. Each slot offers one byte. A slot masks its byte with its own select line and ORs the result into a chain that runs past it. Rather than run one long chain per byte lane, the slots are spread over four interleaved chains: slot k feeds lane k mod 4. Adjacent slots therefore sit on different lanes. Each chain starts from zero, so an idle bus reads as all zeros.

A module can span one or more consecutive slots, and it may start at any of them. Its lowest byte then lands on whichever lane its first slot feeds. On the master side, a rotation driven by a 2-bit alignment select (the module's starting lane) puts the lanes back in byte order. A narrow module returns only its low bytes. When several modules are selected at once, their data merge as a wired OR. The merged lanes are combinational. A read strobe loads the aligned 32-bit word into an output register.

Top module: `rdmux_top`

## Requirements
- R1: After reset, rd_data_o is zero.
- R2: With no slot selected, every lane of lane_o is zero, and a read returns zero.
- R3: The byte of an unselected slot has no effect on lane_o or on the read result.
- R4: Slot k places its byte (slot_data_i bits 8k+7..8k) on byte lane k mod 4 of lane_o (bits 8L+7..8L for lane L).
- R5: For a read with alignment a, byte j of the result (bits 8j+7..8j) equals lane (j+a) mod 4 of lane_o.
- R6: A 32-bit module on four consecutive slots starting at slot s, read with alignment s mod 4, returns the byte of slot s+j in byte j, for every start offset 0..3.
- R7: A module narrower than 32 bits, read with its own alignment, returns its bytes in the low bytes of the result, and every byte above its width is zero.
- R8: When several modules are selected, lane_o and the read result are the bitwise OR of what each module returns alone.
- R9: rd_data_o loads on the rising clock edge where rd_i is high, and holds its value on every edge where rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_data_i | input | 8*NUM_SLOTS | Byte from each slot; slot k in bits 8k+7..8k |
| slot_sel_i | input | NUM_SLOTS | Per-slot select |
| align_i | input | 2 | Starting lane of the module being read |
| rd_i | input | 1 | Read strobe |
| lane_o | output | 32 | Combinational chain outputs, lane L in bits 8L+7..8L |
| rd_data_o | output | 32 | Registered aligned read word |

## Verification
lane_o is combinational, so the bench checks it shortly after changing the inputs at the falling edge, with no clock edge in between. rd_data_o is valid one rising edge after the strobe. The bench drives the strobe at a falling edge and reads the output at the next falling edge. It also confirms that the old value is still present before that rising edge. For hold checks, the strobe stays low across an edge while the slot inputs change, and the output is compared again one edge later.

// File: rtl/rdmux_pkg.sv
package rdmux_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int DATA_W = LANE_W * LANES;

  function automatic logic [DATA_W-1:0] rotate_lanes(input logic [DATA_W-1:0] lanes,
                                                     input logic [1:0] align);
    logic [DATA_W-1:0] r;
    for (int j = 0; j < LANES; j++) begin
      r[j*LANE_W +: LANE_W] = lanes[((j + int'(align)) % LANES)*LANE_W +: LANE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/rdmux_slot_cell.sv
module rdmux_slot_cell
  import rdmux_pkg::*;
(
  input  logic [LANE_W-1:0] chain_i,
  input  logic [LANE_W-1:0] data_i,
  input  logic              sel_i,
  output logic [LANE_W-1:0] chain_o
);
  assign chain_o = chain_i | (data_i & {LANE_W{sel_i}});
endmodule

// File: rtl/rdmux_chain.sv
module rdmux_chain
  import rdmux_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic [DEPTH*LANE_W-1:0] data_i,
  input  logic [DEPTH-1:0]        sel_i,
  output logic [LANE_W-1:0]       lane_o
);
  logic [LANE_W-1:0] link [DEPTH+1];

  assign link[0] = '0; // chain head: idle bus reads zero

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    rdmux_slot_cell u_cell (
      .chain_i (link[i]),
      .data_i  (data_i[i*LANE_W +: LANE_W]),
      .sel_i   (sel_i[i]),
      .chain_o (link[i+1])
    );
  end

  assign lane_o = link[DEPTH];
endmodule

// File: rtl/rdmux_align.sv
module rdmux_align
  import rdmux_pkg::*;
(
  input  logic [DATA_W-1:0] lanes_i,
  input  logic [1:0]        align_i,
  output logic [DATA_W-1:0] data_o
);
  logic [LANE_W-1:0] lane_arr [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_unpack
    assign lane_arr[l] = lanes_i[l*LANE_W +: LANE_W];
  end

  for (genvar j = 0; j < LANES; j++) begin : g_byte
    logic [1:0] src;
    assign src = 2'(j) + align_i;
    assign data_o[j*LANE_W +: LANE_W] = lane_arr[src];
  end
endmodule

// File: rtl/rdmux_top.sv
module rdmux_top
  import rdmux_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_SLOTS*LANE_W-1:0] slot_data_i,
  input  logic [NUM_SLOTS-1:0]        slot_sel_i,
  input  logic [1:0]                  align_i,
  input  logic                        rd_i,
  output logic [DATA_W-1:0]           lane_o,
  output logic [DATA_W-1:0]           rd_data_o
);
  localparam int PER_LANE = NUM_SLOTS / LANES;

  logic [DATA_W-1:0] aligned;
  logic [DATA_W-1:0] rd_q;

  // lane l collects slots l, l+4, l+8, ...
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PER_LANE*LANE_W-1:0] ldata;
    logic [PER_LANE-1:0]        lsel;
    for (genvar i = 0; i < PER_LANE; i++) begin : g_tap
      assign ldata[i*LANE_W +: LANE_W] = slot_data_i[(i*LANES+l)*LANE_W +: LANE_W];
      assign lsel[i]                   = slot_sel_i[i*LANES+l];
    end
    rdmux_chain #(.DEPTH(PER_LANE)) u_chain (
      .data_i (ldata),
      .sel_i  (lsel),
      .lane_o (lane_o[l*LANE_W +: LANE_W])
    );
  end

  rdmux_align u_align (
    .lanes_i (lane_o),
    .align_i (align_i),
    .data_o  (aligned)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (rd_i) rd_q <= aligned;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/rdmux_chk.sv
module rdmux_chk
  import rdmux_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_SLOTS*LANE_W-1:0] slot_data_i,
  input logic [NUM_SLOTS-1:0]        slot_sel_i,
  input logic [1:0]                  align_i,
  input logic                        rd_i,
  input logic [DATA_W-1:0]           lane_o,
  input logic [DATA_W-1:0]           rd_data_o
);
  // union of all slot bytes per lane, selected or not
  logic [DATA_W-1:0] lane_cap;
  always_comb begin
    lane_cap = '0;
    for (int k = 0; k < NUM_SLOTS; k++)
      lane_cap[(k % LANES)*LANE_W +: LANE_W] |= slot_data_i[k*LANE_W +: LANE_W];
  end

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_sel_i == '0) |-> (lane_o == '0)) else $error("idle lanes not zero"); // R2

  AST_LANE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_o & ~lane_cap) == '0) else $error("lane bit without source slot"); // R4

  AST_READ_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (rd_data_o == rotate_lanes($past(lane_o), $past(align_i))))
    else $error("read word not aligned lanes"); // R5

  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o)) else $error("read word changed without strobe"); // R9
endmodule

bind rdmux_top rdmux_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slot_data_i (slot_data_i),
  .slot_sel_i  (slot_sel_i),
  .align_i     (align_i),
  .rd_i        (rd_i),
  .lane_o      (lane_o),
  .rd_data_o   (rd_data_o)
);

// File: tb/tb_rdmux_top.sv
module tb_rdmux_top;
  localparam int NS = 8;
  localparam int DW = NS * 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] slot_data_i = '0;
  logic [NS-1:0] slot_sel_i = '0;
  logic [1:0]    align_i = '0;
  logic          rd_i = 1'b0;
  logic [31:0]   lane_o, rd_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  rdmux_top #(.NUM_SLOTS(NS)) dut (.*);

  always #2 clk_i = ~clk_i;

  function automatic logic [31:0] exp_lanes(logic [DW-1:0] d, logic [NS-1:0] s);
    logic [31:0] r = '0;
    for (int k = 0; k < NS; k++) if (s[k]) r[(k%4)*8 +: 8] |= d[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_rot(logic [31:0] l, logic [1:0] a);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[j*8 +: 8] = l[((j + int'(a)) % 4)*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_pack(logic [DW-1:0] d, int s, int w);
    logic [31:0] r = '0;
    for (int j = 0; j < w; j++) r[j*8 +: 8] = d[(s+j)*8 +: 8];
    return r;
  endfunction

  function automatic logic [NS-1:0] mod_sel(int s, int w);
    logic [NS-1:0] m = '0;
    for (int j = 0; j < w; j++) m[s+j] = 1'b1;
    return m;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rand_data();
    for (int k = 0; k < NS; k++) slot_data_i[k*8 +: 8] = 8'($urandom);
  endtask

  // drive at negedge, strobe, sample at the following negedge
  task automatic do_read(logic [NS-1:0] s, logic [1:0] a);
    @(negedge clk_i);
    slot_sel_i = s; align_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (2) @(negedge clk_i);
    check("R1", rd_data_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", rd_data_o, '0);

    // R2 idle
    rand_data();
    do_read('0, 2'd1);
    check("R2", lane_o, '0);
    check("R2", rd_data_o, '0);

    // R4 each slot on its lane; R3 unselected data ignored
    for (int k = 0; k < NS; k++) begin
      logic [31:0] l0;
      @(negedge clk_i);
      rand_data(); slot_sel_i = NS'(1) << k;
      #1;
      check("R4", lane_o, exp_lanes(slot_data_i, slot_sel_i));
      l0 = lane_o;
      for (int m = 0; m < NS; m++) if (m != k) slot_data_i[m*8 +: 8] = ~slot_data_i[m*8 +: 8];
      #1;
      check("R3", lane_o, l0);
    end

    // R6 full modules at start offsets 0..3 and beyond
    for (int s = 0; s <= NS-4; s++) begin
      rand_data();
      do_read(mod_sel(s, 4), 2'(s % 4));
      check("R6", rd_data_o, exp_pack(slot_data_i, s, 4));
    end

    // R7 narrow modules
    for (int s = 0; s < NS; s++) begin
      rand_data();
      do_read(mod_sel(s, 1), 2'(s % 4));
      check("R7", rd_data_o, exp_pack(slot_data_i, s, 1));
      if (s <= NS-2) begin
        do_read(mod_sel(s, 2), 2'(s % 4));
        check("R7", rd_data_o, exp_pack(slot_data_i, s, 2));
      end
    end

    // R5 alignment sweep
    rand_data();
    for (int a = 0; a < 4; a++) begin
      logic [NS-1:0] s = NS'($urandom);
      do_read(s, 2'(a));
      check("R5", rd_data_o, exp_rot(exp_lanes(slot_data_i, s), 2'(a)));
    end

    // R9 load timing and hold
    begin
      logic [31:0] old;
      rand_data();
      do_read(mod_sel(0, 4), 2'd0);
      old = rd_data_o;
      @(negedge clk_i);
      rand_data(); slot_sel_i = mod_sel(4, 4); rd_i = 1'b0;
      @(negedge clk_i);
      check("R9", rd_data_o, old);
      rd_i = 1'b1;
      @(posedge clk_i); #0;
      check("R9", rd_data_o, old);
      @(negedge clk_i);
      rd_i = 1'b0;
      check("R9", rd_data_o, exp_pack(slot_data_i, 4, 4));
    end

    // R8 multicast
    rand_data();
    do_read(mod_sel(0, 2) | mod_sel(4, 2), 2'd0);
    check("R8", rd_data_o, exp_pack(slot_data_i, 0, 2) | exp_pack(slot_data_i, 4, 2));
    check("R8", lane_o, exp_lanes(slot_data_i, mod_sel(0, 2)) | exp_lanes(slot_data_i, mod_sel(4, 2)));

    // random modules and multicast
    for (int it = 0; it < 200; it++) begin
      int w, s;
      rand_data();
      if ($urandom % 4 == 0) begin
        logic [NS-1:0] m = NS'($urandom);
        logic [1:0] a = 2'($urandom);
        do_read(m, a);
        check("R8", rd_data_o, exp_rot(exp_lanes(slot_data_i, m), a));
      end else begin
        w = (it % 3 == 0) ? 1 : (it % 3 == 1) ? 2 : 4;
        s = int'($urandom % (NS - w + 1));
        do_read(mod_sel(s, w), 2'(s % 4));
        check(w == 4 ? "R6" : "R7", rd_data_o, exp_pack(slot_data_i, s, w));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule